// File: doc/BRIEF.md
# Single-Shot Link Read-Write Element

This block is a very small processing element. After its own reset is released it does exactly two things and then stays quiet. In the first cycle after release it samples one word from a chosen input link. In the second cycle it drives that word, XORed with a device-unique constant, onto a chosen output link. Two small configuration registers choose the links. A management agent fills them over a simple register bus while the element is still held in reset.

Each configuration register holds an optional link index. When the read selection is unset, the sampled word is zero. When the write selection is unset, no output link is driven. The configuration survives the element's own reset and is cleared only by the global reset. A host can therefore load a schedule once and then release the element at exactly the cycle it has computed.

Top module: `oneshot_link_pe`

## Requirements
- R1: A global reset (`rst` high) clears both configuration registers to the value 0, which means unset. It also re-arms the sequencer.
- R2: A bus write (`cfg_we` high at a rising edge) stores `cfg_wdata` into the register chosen by `cfg_addr`: 0 is the read-link register and 1 is the write-link register. `cfg_rdata` shows the addressed register in the same cycle. The field layout is bit 3 = valid and bits 2:0 = link index.
- R3: Both configuration registers keep their values while `pe_rst` is asserted and released.
- R4: The first active cycle is the first rising edge at which `pe_rst` is low. At that edge the element captures the word on the configured read link. A later change on that link has no effect on the result. If the read register is unset, zero is captured.
- R5: In the second active cycle, `link_out` for the configured write link carries the captured word XOR `DEV_ID`, and its strobe in `link_out_vld` is high. This lasts for exactly one cycle.
- R6: If the write register is unset (valid bit 0), no strobe rises and every output word stays zero during the second active cycle.
- R7: A register that has the valid bit set but an index of 7 or more (that is, not below `N_LINKS`) acts exactly as if it were unset, for both reading and writing.
- R8: At most one strobe is high at any time. Every output word whose strobe is low is zero.
- R9: While `pe_rst` is high, and after the write cycle until the next assertion of `pe_rst`, all strobes and output words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Global synchronous reset, active high |
| pe_rst | input | 1 | Element reset, active high; releasing it starts the two-cycle shot |
| cfg_we | input | 1 | Register bus write enable |
| cfg_addr | input | 1 | Register select: 0 read-link, 1 write-link |
| cfg_wdata | input | 4 | Write data: bit 3 valid, bits 2:0 link index |
| cfg_rdata | output | 4 | Contents of the addressed register |
| link_in | input | N_LINKS*LINK_W | Input link words, link i at bits i*LINK_W upward |
| link_out | output | N_LINKS*LINK_W | Output link words, same packing |
| link_out_vld | output | N_LINKS | Per-link write strobe |

## Verification
The hardest point to reach is the single capture edge. Its input word must be present at exactly the first edge after release, and it must be shown to be ignored one edge later. The stimulus therefore releases `pe_rst` and loads a distinct pattern on every link at the same falling edge. Just after the capture edge it replaces every link with a different pattern, so a design that samples a cycle early or late produces a visibly wrong word. Out-of-range indices are placed on both registers, so that the gating of the read side and of the write side is each seen on its own.

// File: rtl/oslpe_pkg.sv
package oslpe_pkg;

    localparam int IDX_W = 3;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } link_sel_t;

    typedef enum logic [1:0] {
        PH_ARMED = 2'd0,
        PH_WRITE = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

    function automatic logic sel_usable(link_sel_t s, int n_links);
        return s.valid && (int'(s.idx) < n_links);
    endfunction

endpackage

// File: rtl/oslpe_cfg_regs.sv
module oslpe_cfg_regs
    import oslpe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  logic      addr,
    input  link_sel_t wdata,
    output link_sel_t rd_sel,
    output link_sel_t wr_sel,
    output link_sel_t rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_sel <= '0;
            wr_sel <= '0;
        end else if (we) begin
            if (addr) wr_sel <= wdata;
            else      rd_sel <= wdata;
        end
    end

    assign rdata = addr ? wr_sel : rd_sel;
endmodule

// File: rtl/oslpe_seq.sv
module oslpe_seq
    import oslpe_pkg::*;
#(
    parameter int LINK_W  = 64,
    parameter int N_LINKS = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pe_rst,
    input  logic [N_LINKS*LINK_W-1:0] link_in,
    input  link_sel_t                 rd_sel,
    output phase_e                    phase,
    output logic [LINK_W-1:0]         captured
);
    logic [LINK_W-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_LINKS; i++) begin
            if (sel_usable(rd_sel, N_LINKS) && int'(rd_sel.idx) == i)
                rd_word = link_in[i*LINK_W +: LINK_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pe_rst) begin
            phase    <= PH_ARMED;
            captured <= '0;
        end else begin
            case (phase)
                PH_ARMED: begin
                    captured <= rd_word;
                    phase    <= PH_WRITE;
                end
                PH_WRITE: phase <= PH_DONE;
                default:  phase <= PH_DONE;
            endcase
        end
    end
endmodule

// File: rtl/oslpe_out_demux.sv
module oslpe_out_demux
    import oslpe_pkg::*;
#(
    parameter int               LINK_W  = 64,
    parameter int               N_LINKS = 7,
    parameter logic [LINK_W-1:0] DEV_ID = '0
) (
    input  phase_e                    phase,
    input  link_sel_t                 wr_sel,
    input  logic [LINK_W-1:0]         captured,
    output logic [N_LINKS*LINK_W-1:0] link_out,
    output logic [N_LINKS-1:0]        link_out_vld
);
    logic              fire;
    logic [LINK_W-1:0] result;

    assign fire   = (phase == PH_WRITE) && sel_usable(wr_sel, N_LINKS);
    assign result = captured ^ DEV_ID;

    for (genvar g = 0; g < N_LINKS; g++) begin : g_lane
        logic hit;
        assign hit = fire && (int'(wr_sel.idx) == g);
        assign link_out_vld[g] = hit;
        assign link_out[g*LINK_W +: LINK_W] = hit ? result : '0;
    end
endmodule

// File: rtl/oneshot_link_pe.sv
module oneshot_link_pe
    import oslpe_pkg::*;
#(
    parameter int               LINK_W  = 64,
    parameter int               N_LINKS = 7,
    parameter logic [LINK_W-1:0] DEV_ID = 64'h0123_4567_89AB_CDEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pe_rst,
    input  logic                      cfg_we,
    input  logic                      cfg_addr,
    input  logic [IDX_W:0]            cfg_wdata,
    output logic [IDX_W:0]            cfg_rdata,
    input  logic [N_LINKS*LINK_W-1:0] link_in,
    output logic [N_LINKS*LINK_W-1:0] link_out,
    output logic [N_LINKS-1:0]        link_out_vld
);
    link_sel_t         rd_sel;
    link_sel_t         wr_sel;
    link_sel_t         rdata_s;
    phase_e            phase;
    logic [LINK_W-1:0] captured;

    oslpe_cfg_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (link_sel_t'(cfg_wdata)),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel),
        .rdata  (rdata_s)
    );
    assign cfg_rdata = rdata_s;

    oslpe_seq #(.LINK_W(LINK_W), .N_LINKS(N_LINKS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .pe_rst   (pe_rst),
        .link_in  (link_in),
        .rd_sel   (rd_sel),
        .phase    (phase),
        .captured (captured)
    );

    oslpe_out_demux #(.LINK_W(LINK_W), .N_LINKS(N_LINKS), .DEV_ID(DEV_ID)) u_out (
        .phase        (phase),
        .wr_sel       (wr_sel),
        .captured     (captured),
        .link_out     (link_out),
        .link_out_vld (link_out_vld)
    );
endmodule

// File: rtl/oslpe_checker.sv
module oslpe_checker
    import oslpe_pkg::*;
#(
    parameter int LINK_W  = 64,
    parameter int N_LINKS = 7
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      pe_rst,
    input logic                      cfg_we,
    input link_sel_t                 rd_sel,
    input link_sel_t                 wr_sel,
    input logic [N_LINKS*LINK_W-1:0] link_out,
    input logic [N_LINKS-1:0]        link_out_vld
);
    a_r1_reset_clears_cfg: assert property (@(posedge clk)
        rst |=> (rd_sel == '0 && wr_sel == '0));

    a_r3_cfg_kept_without_write: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(rd_sel) && $stable(wr_sel)));

    a_r5_strobe_two_after_release: assert property (@(posedge clk) disable iff (rst)
        (link_out_vld != '0) |-> (!$past(pe_rst) && $past(pe_rst, 2)));

    a_r6_unset_write_silent: assert property (@(posedge clk) disable iff (rst)
        !(wr_sel.valid && int'(wr_sel.idx) < N_LINKS) |-> (link_out_vld == '0));

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(link_out_vld));

    a_r8_quiet_words: assert property (@(posedge clk) disable iff (rst)
        (link_out_vld == '0) |-> (link_out == '0));

    a_r9_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
        pe_rst |-> (link_out_vld == '0));
endmodule

bind oneshot_link_pe oslpe_checker #(.LINK_W(LINK_W), .N_LINKS(N_LINKS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pe_rst       (pe_rst),
    .cfg_we       (cfg_we),
    .rd_sel       (rd_sel),
    .wr_sel       (wr_sel),
    .link_out     (link_out),
    .link_out_vld (link_out_vld)
);

// File: tb/oneshot_link_pe_bench.sv
`timescale 1ns/1ps
module oneshot_link_pe_bench;
    localparam int LW = 64;
    localparam int NL = 7;
    localparam logic [LW-1:0] DEV = 64'h0123_4567_89AB_CDEF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pe_rst = 1'b1;
    logic cfg_we = 1'b0;
    logic cfg_addr = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic [3:0] cfg_rdata;
    logic [NL*LW-1:0] link_in = '0;
    logic [NL*LW-1:0] link_out;
    logic [NL-1:0] link_out_vld;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    oneshot_link_pe #(.LINK_W(LW), .N_LINKS(NL), .DEV_ID(DEV)) u_oneshot_link_pe (
        .clk(clk), .rst(rst), .pe_rst(pe_rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .link_in(link_in), .link_out(link_out), .link_out_vld(link_out_vld)
    );

    function automatic logic [LW-1:0] pat(int i, int seed);
        return {32'(seed) * 32'h9E37_79B9, 32'(i + 1) * 32'h1111_1111} ^ 64'hC3C3_0F0F_5A5A_9696;
    endfunction

    task automatic check(string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_idle(string req);
        check(req, "strobes idle", LW'(link_out_vld), '0);
        check(req, "words idle", LW'(|link_out), '0);
    endtask

    task automatic bus_wr(logic a, logic [3:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic bus_rd_check(string req, logic a, logic [3:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, a ? "write-link reg" : "read-link reg", LW'(cfg_rdata), LW'(exp));
    endtask

    // One shot: program, release pe_rst, check capture/write/quiet windows.
    task automatic run_shot(string req, logic [3:0] rd_cfg, logic [3:0] wr_cfg, int seed);
        logic [LW-1:0] exp_word;
        logic rd_ok, wr_ok;
        @(negedge clk);
        pe_rst = 1'b1;
        bus_wr(1'b0, rd_cfg);
        bus_wr(1'b1, wr_cfg);
        check_idle("R9");
        rd_ok = rd_cfg[3] && (int'(rd_cfg[2:0]) < NL);
        wr_ok = wr_cfg[3] && (int'(wr_cfg[2:0]) < NL);
        exp_word = (rd_ok ? pat(int'(rd_cfg[2:0]), seed) : '0) ^ DEV;
        @(negedge clk);
        for (int i = 0; i < NL; i++) link_in[i*LW +: LW] = pat(i, seed);
        pe_rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NL; i++) link_in[i*LW +: LW] = pat(i, seed + 77);
        #1;
        for (int i = 0; i < NL; i++) begin
            logic hit;
            hit = wr_ok && (int'(wr_cfg[2:0]) == i);
            check(req, $sformatf("strobe %0d", i), LW'(link_out_vld[i]), LW'(hit));
            check(req, $sformatf("word %0d", i), link_out[i*LW +: LW], hit ? exp_word : '0);
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_idle("R9");
        end
    endtask

    task automatic t_reset();
        bus_rd_check("R1", 1'b0, 4'h0);
        bus_rd_check("R1", 1'b1, 4'h0);
        check_idle("R8");
    endtask

    task automatic t_cfg_rw();
        bus_wr(1'b0, 4'hA);
        bus_wr(1'b1, 4'hD);
        bus_rd_check("R2", 1'b0, 4'hA);
        bus_rd_check("R2", 1'b1, 4'hD);
    endtask

    task automatic t_retain();
        @(negedge clk); pe_rst = 1'b1;
        repeat (3) @(negedge clk);
        pe_rst = 1'b0;
        repeat (3) @(negedge clk);
        bus_rd_check("R3", 1'b0, 4'hB);
        bus_rd_check("R3", 1'b1, 4'hC);
    endtask

    task automatic t_global_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        bus_rd_check("R1", 1'b0, 4'h0);
        bus_rd_check("R1", 1'b1, 4'h0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_cfg_rw();
                run_shot("R5", 4'hA, 4'hD, 3);    // read link 2, write link 5
                run_shot("R4", 4'h0, 4'h8, 5);    // read unset -> DEV on link 0
                run_shot("R4", 4'hE, 4'hE, 9);    // read link 6 echoed to link 6
                run_shot("R6", 4'hE, 4'h3, 11);   // write valid bit clear
                run_shot("R7", 4'hF, 4'h9, 13);   // read index 7 -> zero captured
                run_shot("R7", 4'h9, 4'hF, 17);   // write index 7 -> nothing
                run_shot("R5", 4'h8, 4'hB, 21);   // read link 0, write link 3
                bus_wr(1'b0, 4'hB);
                bus_wr(1'b1, 4'hC);
                t_retain();
                t_global_reset();
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule